// File: doc/BRIEF.md
# Receive Stream Address Filter

This block sits between a character receiver and a receive FIFO. It decides, one character at a time, whether a received character is written into the FIFO. The decision uses address characters carried in the stream. One stored address register is compared against every address character. A matching address opens the stream, so that the address and the data after it are written. A non-matching address closes the stream, and FIFO writes stop until another match arrives.

The register has two matching modes. In domain mode, each bit of the register stands for one group, and an address matches when it shares at least one set bit with the register. In exact mode, the address must equal the register in every bit. A promiscuous setting is loaded at reset: domain mode with every bit set. With that setting every character is forwarded. Filtering is also skipped when the FIFO path is disabled or the discard policy is 0. Policy 3 forwards the data behind a matching address but drops the address character itself.

Software reads and writes the register over a shared bus. An access needs both the device-select and the receiver-reset inputs held low. While the receiver reset is low, received characters are ignored.

Top module: `rx_addr_filter`

## Requirements
- R1: After `rst_n` is sampled low, the register reads back as all ones in domain mode (`bus_rmode` = 0). `fifo_we` is 0 and the stream is open.
- R2: While the register holds all ones in domain mode, every valid character is forwarded. This includes address characters that share no bit with the register.
- R3: In domain mode (`acc_exact` = 0 at write), an address matches when its bitwise AND with the register is nonzero.
- R4: In exact mode (`acc_exact` = 1 at write), an address matches only when it equals the register in every bit.
- R5: When filtering is active, a matching address opens the stream, and the address plus the data after it are forwarded. A non-matching address is not forwarded, and it closes the stream for the data after it.
- R6: Under discard policy 3 (`policy` = 2'b11), a matching address character is not forwarded, but the data after it is.
- R7: With `fifo_enabled` = 0 or `policy` = 2'b00, every valid character is forwarded regardless of address content.
- R8: The register is written with `bus_wdata`, and its mode with `acc_exact`, in a cycle where `dev_sel_n` = 0, `rx_rst_n` = 0 and `acc_rd` = 0. In any other cycle a write request leaves the register unchanged.
- R9: `bus_oe` is 1 and `bus_rdata` carries the register only while `dev_sel_n` = 0, `rx_rst_n` = 0 and `acc_rd` = 1. At other times `bus_oe` and `bus_rdata` are 0.
- R10: An accepted character raises `fifo_we` for exactly the next cycle. In that cycle `fifo_data` carries the character and `fifo_is_addr` carries its address flag.
- R11: After a register write that is not the promiscuous value, the stream starts closed. Data that arrives before the first matching address is dropped.
- R12: A character presented while `rx_rst_n` = 0 is never forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the promiscuous value |
| chr_valid | input | 1 | Received character strobe |
| chr_value | input | CHAR_W | Received character |
| chr_is_addr | input | 1 | 1 = character is an address, 0 = data |
| fifo_enabled | input | 1 | 1 = FIFO path in use, so filtering may apply |
| policy | input | 2 | Discard policy code; 0 disables filtering, 3 strips matching address |
| dev_sel_n | input | 1 | Device select for register access, active low |
| rx_rst_n | input | 1 | Receiver reset, active low; must be low for access |
| acc_rd | input | 1 | Access direction: 1 = read, 0 = write |
| acc_exact | input | 1 | Mode written with the register: 1 = exact, 0 = domain |
| bus_wdata | input | CHAR_W | Register write value |
| bus_rdata | output | CHAR_W | Register read value, 0 outside a read |
| bus_rmode | output | 1 | Register mode read value, 0 outside a read |
| bus_oe | output | 1 | 1 while read data is driven |
| fifo_we | output | 1 | FIFO write enable, registered |
| fifo_data | output | CHAR_W | Character written to the FIFO |
| fifo_is_addr | output | 1 | Address flag of the written character |

## Verification
The hardest condition to reach from the ports is a closed stream under active filtering. Getting there takes three steps in order: a register access with the receiver held in reset, release of that reset, and then a stream of addresses and data. The bench first writes a domain value through the access port. It then walks a table of characters that starts with data before any address (R11). It follows with a missing address, a hit, data, a miss that closes the stream, and a later reopen. Exact mode and the address-stripping policy reuse the same sequence with a second register write. The promiscuous case, the blocked access and the character ignored under receiver reset each get a directed test.

// File: rtl/rx_addr_filter_pkg.sv
// Shared types for the receive stream address filter.
package rx_addr_filter_pkg;
    typedef enum logic {
        MODE_DOMAIN = 1'b0,
        MODE_EXACT  = 1'b1
    } match_mode_e;

    localparam logic [1:0] POL_OPEN  = 2'd0;
    localparam logic [1:0] POL_STRIP = 2'd3;
endpackage

// File: rtl/raf_addr_reg.sv
// Address register with bus access.
// Holds the match value and mode. A write is taken when device select and
// receiver reset are both low and the direction is write. Read data is driven
// only during a read access. Assumes the access lines are synchronous to clk.
module raf_addr_reg
    import rx_addr_filter_pkg::*;
#(
    parameter int CHAR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_sel_n,
    input  logic              rx_rst_n,
    input  logic              acc_rd,
    input  logic              acc_exact,
    input  logic [CHAR_W-1:0] bus_wdata,
    output logic [CHAR_W-1:0] addr_value,
    output match_mode_e       addr_mode,
    output logic              reg_written,
    output logic [CHAR_W-1:0] bus_rdata,
    output logic              bus_rmode,
    output logic              bus_oe
);
    logic acc_live;
    logic wr_access;

    // Decode an access window and its direction.
    always_comb begin
        acc_live  = !dev_sel_n && !rx_rst_n;
        wr_access = acc_live && !acc_rd;
    end

    // Load the register on write, promiscuous value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_value <= '1;
            addr_mode  <= MODE_DOMAIN;
        end else if (wr_access) begin
            addr_value <= bus_wdata;
            addr_mode  <= acc_exact ? MODE_EXACT : MODE_DOMAIN;
        end
    end

    // Tell the pass tracker that the register was replaced.
    always_comb reg_written = wr_access;

    // Drive read data only while a read access is open.
    always_comb begin
        bus_oe    = acc_live && acc_rd;
        bus_rdata = bus_oe ? addr_value : '0;
        bus_rmode = bus_oe ? (addr_mode == MODE_EXACT) : 1'b0;
    end

    AST_REG_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_access) |=> (addr_value == $past(bus_wdata))); // R8
endmodule

// File: rtl/raf_matcher.sv
// Address comparator.
// Domain mode hits when any register bit is shared with the address. Exact
// mode hits on full equality. Purely combinational.
module raf_matcher
    import rx_addr_filter_pkg::*;
#(
    parameter int CHAR_W = 10
) (
    input  logic [CHAR_W-1:0] chr_value,
    input  logic [CHAR_W-1:0] addr_value,
    input  match_mode_e       addr_mode,
    output logic              addr_hit,
    output logic              promisc
);
    logic [CHAR_W-1:0] domain_hits;

    genvar gi;
    generate
        for (gi = 0; gi < CHAR_W; gi++) begin : g_domain
            // One group bit shared by address and register.
            assign domain_hits[gi] = chr_value[gi] & addr_value[gi];
        end
    endgenerate

    // Pick the match rule for the current mode.
    always_comb begin
        if (addr_mode == MODE_EXACT) addr_hit = (chr_value == addr_value);
        else                         addr_hit = |domain_hits;
        promisc = (addr_mode == MODE_DOMAIN) && (&addr_value);
    end
endmodule

// File: rtl/raf_pass_track.sv
// Sticky pass/inhibit state.
// Opens on a matching address and closes on a missing one. It closes when the
// register is rewritten and opens on reset, when the promiscuous value is
// loaded.
module raf_pass_track (
    input  logic clk,
    input  logic rst_n,
    input  logic reg_written,
    input  logic addr_evt,
    input  logic addr_hit,
    output logic pass_open
);
    // Track whether data characters may be forwarded.
    always_ff @(posedge clk) begin
        if (!rst_n)           pass_open <= 1'b1;
        else if (reg_written) pass_open <= 1'b0;
        else if (addr_evt)    pass_open <= addr_hit;
    end

    AST_MISS_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && addr_evt && !addr_hit && !reg_written) |=> !pass_open); // R5
endmodule

// File: rtl/rx_addr_filter.sv
// Receive stream address filter, top level.
// Gates FIFO writes of received characters using address characters in the
// stream. Filtering applies only with the FIFO path on, a nonzero policy and a
// non-promiscuous register. Characters under receiver reset are ignored. The
// write enable is registered, one cycle after the character.
module rx_addr_filter
    import rx_addr_filter_pkg::*;
#(
    parameter int CHAR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_valid,
    input  logic [CHAR_W-1:0] chr_value,
    input  logic              chr_is_addr,
    input  logic              fifo_enabled,
    input  logic [1:0]        policy,
    input  logic              dev_sel_n,
    input  logic              rx_rst_n,
    input  logic              acc_rd,
    input  logic              acc_exact,
    input  logic [CHAR_W-1:0] bus_wdata,
    output logic [CHAR_W-1:0] bus_rdata,
    output logic              bus_rmode,
    output logic              bus_oe,
    output logic              fifo_we,
    output logic [CHAR_W-1:0] fifo_data,
    output logic              fifo_is_addr
);
    logic [CHAR_W-1:0] addr_value;
    match_mode_e       addr_mode;
    logic              reg_written;
    logic              addr_hit;
    logic              promisc;
    logic              pass_open;
    logic              ch_live;
    logic              filtering;
    logic              addr_evt;
    logic              take;

    raf_addr_reg #(.CHAR_W(CHAR_W)) u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_sel_n   (dev_sel_n),
        .rx_rst_n    (rx_rst_n),
        .acc_rd      (acc_rd),
        .acc_exact   (acc_exact),
        .bus_wdata   (bus_wdata),
        .addr_value  (addr_value),
        .addr_mode   (addr_mode),
        .reg_written (reg_written),
        .bus_rdata   (bus_rdata),
        .bus_rmode   (bus_rmode),
        .bus_oe      (bus_oe)
    );

    raf_matcher #(.CHAR_W(CHAR_W)) u_match (
        .chr_value  (chr_value),
        .addr_value (addr_value),
        .addr_mode  (addr_mode),
        .addr_hit   (addr_hit),
        .promisc    (promisc)
    );

    raf_pass_track u_pass (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_written (reg_written),
        .addr_evt    (addr_evt),
        .addr_hit    (addr_hit),
        .pass_open   (pass_open)
    );

    // Decide whether the current character is accepted.
    always_comb begin
        ch_live   = chr_valid && rx_rst_n;
        filtering = fifo_enabled && (policy != POL_OPEN) && !promisc;
        addr_evt  = ch_live && chr_is_addr && filtering;
        if (!ch_live)         take = 1'b0;
        else if (!filtering)  take = 1'b1;
        else if (chr_is_addr) take = addr_hit && (policy != POL_STRIP);
        else                  take = pass_open;
    end

    // Register the FIFO write and its data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_we      <= 1'b0;
            fifo_data    <= '0;
            fifo_is_addr <= 1'b0;
        end else begin
            fifo_we      <= take;
            fifo_data    <= chr_value;
            fifo_is_addr <= chr_is_addr;
        end
    end

    AST_WE_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_we |-> $past(chr_valid)); // R10
    AST_RXRST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !rx_rst_n) |=> !fifo_we); // R12
    AST_STRIP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && addr_evt && policy == POL_STRIP) |=> !fifo_we); // R6
    AST_PROMISC_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && promisc && chr_valid && rx_rst_n) |=> fifo_we); // R2
endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
    localparam int CHAR_W = 10;
    localparam int NVEC   = 10;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              chr_valid;
    logic [CHAR_W-1:0] chr_value;
    logic              chr_is_addr;
    logic              fifo_enabled;
    logic [1:0]        policy;
    logic              dev_sel_n;
    logic              rx_rst_n;
    logic              acc_rd;
    logic              acc_exact;
    logic [CHAR_W-1:0] bus_wdata;
    logic [CHAR_W-1:0] bus_rdata;
    logic              bus_rmode;
    logic              bus_oe;
    logic              fifo_we;
    logic [CHAR_W-1:0] fifo_data;
    logic              fifo_is_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rx_addr_filter #(.CHAR_W(CHAR_W)) u_rx_addr_filter (.*);

    // {valid, is_addr, value[9:0], expected write}; domain register 0x005, policy 1
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 10'h123, 1'b0},  // R11 data before any address
        {1'b1, 1'b1, 10'h002, 1'b0},  // R3 no shared bit
        {1'b1, 1'b1, 10'h004, 1'b1},  // R3 shared bit 2, R5 opens
        {1'b1, 1'b0, 10'h3AA, 1'b1},  // R5
        {1'b1, 1'b0, 10'h055, 1'b1},  // R5
        {1'b1, 1'b1, 10'h100, 1'b0},  // R5 miss closes
        {1'b1, 1'b0, 10'h077, 1'b0},  // R5 closed
        {1'b1, 1'b1, 10'h001, 1'b1},  // R3 reopen
        {1'b0, 1'b0, 10'h000, 1'b0},  // R10 idle gives no write
        {1'b1, 1'b0, 10'h011, 1'b1}   // R5
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Present one character at a negedge, then sample one cycle later.
    task automatic send(input logic v, input logic a, input logic [CHAR_W-1:0] d,
                        input logic exp_we, input string tag);
        chr_valid = v; chr_is_addr = a; chr_value = d;
        @(posedge clk); @(negedge clk);
        chr_valid = 1'b0;
        check(tag, {31'd0, fifo_we}, {31'd0, exp_we});
        if (exp_we) begin
            check(tag, {22'd0, fifo_data}, {22'd0, d});
            check(tag, {31'd0, fifo_is_addr}, {31'd0, a});
        end
    endtask

    task automatic reg_write(input logic [CHAR_W-1:0] val, input logic exact,
                             input logic sel_n, input logic rrst_n);
        dev_sel_n = sel_n; rx_rst_n = rrst_n; acc_rd = 1'b0;
        acc_exact = exact; bus_wdata = val;
        @(posedge clk); @(negedge clk);
        dev_sel_n = 1'b1; rx_rst_n = 1'b1;
    endtask

    task automatic reg_read(input logic [CHAR_W-1:0] exp_val, input logic exp_mode,
                            input string tag);
        dev_sel_n = 1'b0; rx_rst_n = 1'b0; acc_rd = 1'b1;
        #1;
        check(tag, {31'd0, bus_oe}, 32'd1);
        check(tag, {22'd0, bus_rdata}, {22'd0, exp_val});
        check(tag, {31'd0, bus_rmode}, {31'd0, exp_mode});
        @(negedge clk);
        dev_sel_n = 1'b1; rx_rst_n = 1'b1; acc_rd = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; chr_valid = 1'b0; chr_value = '0; chr_is_addr = 1'b0;
        fifo_enabled = 1'b1; policy = 2'd1; dev_sel_n = 1'b1; rx_rst_n = 1'b1;
        acc_rd = 1'b0; acc_exact = 1'b0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 we", {31'd0, fifo_we}, 32'd0);
        reg_read(10'h3FF, 1'b0, "R1 readback");
        // R9 no drive outside a read
        #1;
        check("R9 oe", {31'd0, bus_oe}, 32'd0);
        check("R9 rdata", {22'd0, bus_rdata}, 32'd0);

        // R2 promiscuous
        send(1'b1, 1'b0, 10'h0AB, 1'b1, "R2 data");
        send(1'b1, 1'b1, 10'h000, 1'b1, "R2 address");
        // R12 ignored while receiver reset low
        rx_rst_n = 1'b0;
        send(1'b1, 1'b0, 10'h0CD, 1'b0, "R12");
        rx_rst_n = 1'b1;

        // R8 blocked writes leave register unchanged
        reg_write(10'h005, 1'b0, 1'b1, 1'b0);
        reg_read(10'h3FF, 1'b0, "R8 sel high");
        reg_write(10'h005, 1'b0, 1'b0, 1'b1);
        reg_read(10'h3FF, 1'b0, "R8 rxrst high");
        reg_write(10'h005, 1'b0, 1'b0, 1'b0);
        reg_read(10'h005, 1'b0, "R8 write taken");

        // Table walk, domain mode
        for (int i = 0; i < NVEC; i++)
            send(VEC[i][12], VEC[i][11], VEC[i][10:1], VEC[i][0], $sformatf("vec %0d", i));

        // R4 exact mode
        reg_write(10'h2A5, 1'b1, 1'b0, 1'b0);
        reg_read(10'h2A5, 1'b1, "R8 exact write");
        send(1'b1, 1'b0, 10'h044, 1'b0, "R11 exact closed");
        send(1'b1, 1'b1, 10'h2A4, 1'b0, "R4 one bit off");
        send(1'b1, 1'b1, 10'h2A5, 1'b1, "R4 exact hit");
        send(1'b1, 1'b0, 10'h0F0, 1'b1, "R5 data after hit");

        // R6 strip policy
        policy = 2'd3;
        send(1'b1, 1'b1, 10'h2A5, 1'b0, "R6 address stripped");
        send(1'b1, 1'b0, 10'h001, 1'b1, "R6 data kept");
        send(1'b1, 1'b1, 10'h2A4, 1'b0, "R6 miss");
        send(1'b1, 1'b0, 10'h002, 1'b0, "R6 closed");

        // R7 bypass conditions
        policy = 2'd0;
        send(1'b1, 1'b1, 10'h000, 1'b1, "R7 policy 0 address");
        send(1'b1, 1'b0, 10'h003, 1'b1, "R7 policy 0 data");
        policy = 2'd1; fifo_enabled = 1'b0;
        send(1'b1, 1'b1, 10'h111, 1'b1, "R7 fifo off address");
        fifo_enabled = 1'b1;

        // R1 reset restores promiscuous
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        reg_read(10'h3FF, 1'b0, "R1 after reset");
        send(1'b1, 1'b1, 10'h000, 1'b1, "R2 after reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule